// File: doc/BRIEF.md
# Ring Receive Header Parser

This block watches the byte-wide stream a ring physical-layer device hands to its MAC. Each byte holds two four-bit symbols, the earlier one in bits 7..4 (the first bit received sits in bit 7). Every byte carries its own data/control tagging and an odd parity bit. All inputs are sampled on the rising edge of the data clock. The parser checks parity and finds the start of each frame. It then captures the frame control byte, the six destination and six source address bytes, and the routing information field when one is present.

It reports each byte it captures as a one-cycle strobe, classifies the frame, and flags whether a routing field is present and how long it is. It also drives a compare-in-progress window whose two edges sit at fixed distances from the header. Downstream logic uses the strobes to run address lookups and uses the window to tell the MAC side that a decision is pending. Tokens, void frames, management frames and frames with short addresses are classified, and then the parser lets them pass without opening a window.

Top module: `rxhdr_parser`

## Requirements
- R1: Every byte from frame control to the end of the header must have odd total parity over rx_byte, tag_a, rx_parity and tag_b, with tag_b counted only when two_tag_mode=1. A failing byte gives no strobe of its own and raises hdr_err for one cycle after its loading edge, and the frame is dropped. Bytes seen while hunting for a frame start are not checked.
- R2: With two_tag_mode=1, tag_b high marks bits 7..4 as control and tag_a high marks bits 3..0 as control. With two_tag_mode=0, tag_a marks both nibbles and tag_b has no effect. A frame starts on a byte equal to 8'hC5 whose two nibbles are both control, and the byte after it is frame control.
- R3: fc_strobe is high for one cycle after the edge that loaded the frame control byte. At the same time fc_class holds the frame class: 0 token, 1 void, 2 management, 3 MAC, 4 LLC, 5 reserved. fc_filter is 1 only for MAC, LLC or reserved frames whose bit 6 (long-address bit) is set.
- R4: The frame control values 8'h80 and 8'hC0 are tokens (class 0). They produce no address strobe and no compare window.
- R5: Some frames get fc_filter=0, no address strobes and no compare window, and the parser then waits for the next frame start. These are void frames (bits 7..4 equal 0 or 4, bits 3..0 zero), management frames (bits 7, 5 and 4 zero, bits 3..0 nonzero) and every frame with bit 6 clear.
- R6: For a filterable frame, the next six bytes are the destination address and the six after them are the source address. Each byte gives addr_strobe for one cycle after its loading edge, together with addr_sa (0 destination, 1 source), addr_idx 0..5 in arrival order, and addr_byte.
- R7: rif_present takes bit 7 of the first source byte. When it is set, the low 5 bits of the next byte give the routing field length in bytes, counting that byte itself, and rif_len reports that value. hdr_done pulses for one cycle after the edge that loaded the last header byte, with rif_present and rif_len valid (rif_len is 0 when no field is present).
- R8: cip is low after reset. It goes high on the third rising edge after the edge that loaded a filterable frame control byte.
- R9: With no routing field, cip goes low on the seventh rising edge after the edge that loaded the last source byte.
- R10: With a routing field, cip goes low on the seventh rising edge after the edge that loaded the last routing field byte.
- R11: A control nibble in any header byte after the frame start raises hdr_err and drops the frame. cip is low after that same edge, and a rise that is still pending is cancelled.
- R12: A routing field length below 2 is a header error, handled as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| two_tag_mode | input | 1 | 1: separate tag per nibble; 0: tag_a covers both |
| rx_byte | input | 8 | Received symbol pair, first symbol in bits 7..4 |
| tag_a | input | 1 | Control tag for bits 3..0 (both nibbles in one-tag mode) |
| tag_b | input | 1 | Control tag for bits 7..4 in two-tag mode |
| rx_parity | input | 1 | Odd parity over data and active tags |
| fc_strobe | output | 1 | Frame control byte accepted |
| fc_class | output | 3 | Frame class code |
| fc_filter | output | 1 | Frame is subject to address filtering |
| addr_strobe | output | 1 | Address byte captured |
| addr_sa | output | 1 | Captured byte belongs to the source address |
| addr_idx | output | 3 | Byte position within the address |
| addr_byte | output | 8 | Captured address byte |
| rif_present | output | 1 | Routing information field present |
| rif_len | output | 5 | Routing field length in bytes |
| hdr_done | output | 1 | Header complete pulse |
| hdr_err | output | 1 | Header error pulse |
| cip | output | 1 | Compare-in-progress window |

## Verification
The bench checks window edges against exact edge counts. A timer that is off by one moves an edge, and the scoreboard then reports a window event one cycle early or late. Routing fields of length 6 and of illegal length 1 are both sent. A parser that used the wrong length field, or that kept counting past it, would close the window in the wrong cycle or never flag the error. An error that lands before the window opens must cancel the pending rise, and the bench tells a stray late cip pulse apart from none. The one-tag and two-tag cases are covered by a stray tag_b in one-tag mode, which must change neither parity nor control, and by a half-tagged start byte in two-tag mode, which must not start a frame.

// File: rtl/rxhdr_pkg.sv
package rxhdr_pkg;

  typedef enum logic [2:0] {
    FT_TOKEN = 3'd0,
    FT_VOID  = 3'd1,
    FT_SMT   = 3'd2,
    FT_MAC   = 3'd3,
    FT_LLC   = 3'd4,
    FT_RSVD  = 3'd5
  } fc_class_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_FC,
    ST_DA,
    ST_SA,
    ST_RC0,
    ST_RIF
  } hdr_state_e;

  typedef enum logic [1:0] {
    CP_IDLE,
    CP_WAIT_UP,
    CP_ON,
    CP_WAIT_DN
  } cip_phase_e;

  // total count of ones over data, active tags and parity must be odd
  function automatic logic odd_par_ok(input logic [7:0] d, input logic ta,
                                      input logic tb_eff, input logic p);
    return ^{d, ta, tb_eff, p};
  endfunction

  // bit 7 = class bit, bit 6 = long-address bit, bits 5:4 = format
  function automatic fc_class_e fc_classify(input logic [7:0] fc);
    fc_class_e c;
    unique case (fc[5:4])
      2'b00: begin
        if (fc[7]) c = (fc[3:0] == 4'h0) ? FT_TOKEN : FT_MAC;
        else       c = (fc[3:0] == 4'h0) ? FT_VOID  : FT_SMT;
      end
      2'b01:   c = FT_LLC;
      default: c = FT_RSVD;
    endcase
    return c;
  endfunction

  function automatic logic fc_filterable(input logic [7:0] fc);
    fc_class_e c;
    c = fc_classify(fc);
    return fc[6] && (c == FT_MAC || c == FT_LLC || c == FT_RSVD);
  endfunction

  function automatic logic rif_len_bad(input logic [7:0] len);
    return len < 8'd2;
  endfunction

endpackage

// File: rtl/rxhdr_symdec.sv
module rxhdr_symdec
  import rxhdr_pkg::*;
#(
  parameter logic [7:0] SD_CODE = 8'hC5
) (
  input  logic [7:0] rx_byte,
  input  logic       tag_a,
  input  logic       tag_b,
  input  logic       rx_parity,
  input  logic       two_tag_mode,
  output logic       any_ctl,
  output logic       par_ok,
  output logic       sd_hit
);
  logic hi_ctl;
  logic lo_ctl;
  logic tb_eff;

  always_comb begin
    tb_eff  = two_tag_mode & tag_b;
    hi_ctl  = two_tag_mode ? tag_b : tag_a;
    lo_ctl  = tag_a;
    any_ctl = hi_ctl | lo_ctl;
    par_ok  = odd_par_ok(rx_byte, tag_a, tb_eff, rx_parity);
    sd_hit  = hi_ctl & lo_ctl & (rx_byte == SD_CODE);
  end
endmodule

// File: rtl/rxhdr_track.sv
module rxhdr_track
  import rxhdr_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 5,
  parameter int IDX_W      = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte,
  input  logic             any_ctl,
  input  logic             par_ok,
  input  logic             sd_hit,
  output logic             ev_fc_go,
  output logic             ev_end,
  output logic             ev_abort,
  output logic             fc_strobe,
  output fc_class_e        fc_class,
  output logic             fc_filter,
  output logic             addr_strobe,
  output logic             addr_sa,
  output logic [IDX_W-1:0] addr_idx,
  output logic [7:0]       addr_byte,
  output logic             rif_present,
  output logic [LEN_W-1:0] rif_len,
  output logic             hdr_done,
  output logic             hdr_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  hdr_state_e       state, state_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [LEN_W-1:0] rcnt, rcnt_n;
  logic [LEN_W-1:0] len_q;
  logic             rii_q;
  logic             bad, rii_now;
  logic             take_fc, take_addr, take_rc;

  always_comb begin
    bad       = any_ctl | ~par_ok;
    rii_now   = (idx == '0) ? rx_byte[7] : rii_q;
    state_n   = state;
    idx_n     = idx;
    rcnt_n    = rcnt;
    ev_fc_go  = 1'b0;
    ev_end    = 1'b0;
    ev_abort  = 1'b0;
    take_fc   = 1'b0;
    take_addr = 1'b0;
    take_rc   = 1'b0;
    unique case (state)
      ST_HUNT: if (sd_hit) state_n = ST_FC;
      ST_FC: begin
        if (bad) begin
          ev_abort = 1'b1;
          state_n  = ST_HUNT;
        end else begin
          take_fc = 1'b1;
          if (fc_filterable(rx_byte)) begin
            ev_fc_go = 1'b1;
            state_n  = ST_DA;
            idx_n    = '0;
          end else begin
            state_n = ST_HUNT;
          end
        end
      end
      ST_DA: begin
        if (bad) begin
          ev_abort = 1'b1;
          state_n  = ST_HUNT;
        end else begin
          take_addr = 1'b1;
          if (idx == LAST_IDX) begin
            state_n = ST_SA;
            idx_n   = '0;
          end else begin
            idx_n = idx + 1'b1;
          end
        end
      end
      ST_SA: begin
        if (bad) begin
          ev_abort = 1'b1;
          state_n  = ST_HUNT;
        end else begin
          take_addr = 1'b1;
          if (idx == LAST_IDX) begin
            if (rii_now) begin
              state_n = ST_RC0;
            end else begin
              ev_end  = 1'b1;
              state_n = ST_HUNT;
            end
          end else begin
            idx_n = idx + 1'b1;
          end
        end
      end
      ST_RC0: begin
        if (bad || rif_len_bad(8'(rx_byte[LEN_W-1:0]))) begin
          ev_abort = 1'b1;
          state_n  = ST_HUNT;
        end else begin
          take_rc = 1'b1;
          rcnt_n  = LEN_W'(1);
          state_n = ST_RIF;
        end
      end
      ST_RIF: begin
        if (bad) begin
          ev_abort = 1'b1;
          state_n  = ST_HUNT;
        end else if (rcnt == len_q - 1'b1) begin
          ev_end  = 1'b1;
          state_n = ST_HUNT;
        end else begin
          rcnt_n = rcnt + 1'b1;
        end
      end
      default: state_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      idx         <= '0;
      rcnt        <= '0;
      len_q       <= '0;
      rii_q       <= 1'b0;
      fc_strobe   <= 1'b0;
      fc_class    <= FT_TOKEN;
      fc_filter   <= 1'b0;
      addr_strobe <= 1'b0;
      addr_sa     <= 1'b0;
      addr_idx    <= '0;
      addr_byte   <= '0;
      rif_present <= 1'b0;
      rif_len     <= '0;
      hdr_done    <= 1'b0;
      hdr_err     <= 1'b0;
    end else begin
      state       <= state_n;
      idx         <= idx_n;
      rcnt        <= rcnt_n;
      fc_strobe   <= take_fc;
      addr_strobe <= take_addr;
      hdr_done    <= ev_end;
      hdr_err     <= ev_abort;
      if (take_fc) begin
        fc_class  <= fc_classify(rx_byte);
        fc_filter <= fc_filterable(rx_byte);
      end
      if (ev_fc_go) begin
        rif_present <= 1'b0;
        rif_len     <= '0;
        rii_q       <= 1'b0;
      end
      if (take_addr) begin
        addr_sa   <= (state == ST_SA);
        addr_idx  <= idx;
        addr_byte <= rx_byte;
        if (state == ST_SA && idx == '0) begin
          rif_present <= rx_byte[7];
          rii_q       <= rx_byte[7];
        end
      end
      if (take_rc) begin
        rif_len <= rx_byte[LEN_W-1:0];
        len_q   <= rx_byte[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rxhdr_cipgen.sv
module rxhdr_cipgen
  import rxhdr_pkg::*;
#(
  parameter int CIP_RISE = 3,
  parameter int CIP_FALL = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_fc_go,
  input  logic ev_end,
  input  logic ev_abort,
  output logic cip
);
  localparam int MAXD  = (CIP_RISE > CIP_FALL) ? CIP_RISE : CIP_FALL;
  localparam int CNT_W = $clog2(MAXD + 1);

  cip_phase_e       phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= CP_IDLE;
      cnt   <= '0;
      cip   <= 1'b0;
    end else if (ev_abort) begin
      phase <= CP_IDLE;
      cip   <= 1'b0;
    end else if (ev_fc_go) begin
      phase <= CP_WAIT_UP;
      cnt   <= CNT_W'(CIP_RISE - 1);
    end else if (ev_end) begin
      phase <= CP_WAIT_DN;
      cnt   <= CNT_W'(CIP_FALL - 1);
    end else begin
      unique case (phase)
        CP_WAIT_UP: begin
          if (cnt == '0) begin
            cip   <= 1'b1;
            phase <= CP_ON;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CP_WAIT_DN: begin
          if (cnt == '0) begin
            cip   <= 1'b0;
            phase <= CP_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxhdr_parser.sv
module rxhdr_parser
  import rxhdr_pkg::*;
#(
  parameter logic [7:0] SD_CODE    = 8'hC5,
  parameter int         ADDR_BYTES = 6,
  parameter int         LEN_W      = 5,
  parameter int         CIP_RISE   = 3,
  parameter int         CIP_FALL   = 7,
  parameter int         IDX_W      = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_tag_mode,
  input  logic [7:0]       rx_byte,
  input  logic             tag_a,
  input  logic             tag_b,
  input  logic             rx_parity,
  output logic             fc_strobe,
  output logic [2:0]       fc_class,
  output logic             fc_filter,
  output logic             addr_strobe,
  output logic             addr_sa,
  output logic [IDX_W-1:0] addr_idx,
  output logic [7:0]       addr_byte,
  output logic             rif_present,
  output logic [LEN_W-1:0] rif_len,
  output logic             hdr_done,
  output logic             hdr_err,
  output logic             cip
);
  // named internal events, visible to the bound checker
  logic      any_ctl, par_ok, sd_hit;
  logic      ev_fc_go, ev_end, ev_abort;
  fc_class_e fc_class_w;

  rxhdr_symdec #(.SD_CODE(SD_CODE)) u_symdec (
    .rx_byte      (rx_byte),
    .tag_a        (tag_a),
    .tag_b        (tag_b),
    .rx_parity    (rx_parity),
    .two_tag_mode (two_tag_mode),
    .any_ctl      (any_ctl),
    .par_ok       (par_ok),
    .sd_hit       (sd_hit)
  );

  rxhdr_track #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W),
    .IDX_W      (IDX_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_byte     (rx_byte),
    .any_ctl     (any_ctl),
    .par_ok      (par_ok),
    .sd_hit      (sd_hit),
    .ev_fc_go    (ev_fc_go),
    .ev_end      (ev_end),
    .ev_abort    (ev_abort),
    .fc_strobe   (fc_strobe),
    .fc_class    (fc_class_w),
    .fc_filter   (fc_filter),
    .addr_strobe (addr_strobe),
    .addr_sa     (addr_sa),
    .addr_idx    (addr_idx),
    .addr_byte   (addr_byte),
    .rif_present (rif_present),
    .rif_len     (rif_len),
    .hdr_done    (hdr_done),
    .hdr_err     (hdr_err)
  );

  rxhdr_cipgen #(
    .CIP_RISE (CIP_RISE),
    .CIP_FALL (CIP_FALL)
  ) u_cipgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_fc_go (ev_fc_go),
    .ev_end   (ev_end),
    .ev_abort (ev_abort),
    .cip      (cip)
  );

  assign fc_class = fc_class_w;
endmodule

// File: rtl/rxhdr_parser_chk.sv
module rxhdr_parser_chk #(
  parameter int CIP_RISE = 3,
  parameter int CIP_FALL = 7,
  parameter int IDX_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fc_strobe,
  input logic             fc_filter,
  input logic             addr_strobe,
  input logic             addr_sa,
  input logic [IDX_W-1:0] addr_idx,
  input logic             hdr_done,
  input logic             hdr_err,
  input logic             cip,
  input logic             ev_abort
);
  localparam int SW = $clog2(CIP_RISE + CIP_FALL + 4);

  logic [SW-1:0] since_go;
  logic [SW-1:0] since_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_go  <= '1;
      since_end <= '1;
    end else begin
      if (fc_strobe && fc_filter) since_go <= SW'(1);
      else if (since_go != '1)    since_go <= since_go + 1'b1;
      if (hdr_done)               since_end <= SW'(1);
      else if (since_end != '1)   since_end <= since_end + 1'b1;
    end
  end

  // R8: window opens a fixed number of cycles after an accepted frame control
  p_cip_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cip) |-> since_go == SW'(CIP_RISE));

  // R9 and R10: a close that is not an error close follows header end by a fixed count
  p_cip_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cip) && !hdr_err) |-> since_end == SW'(CIP_FALL));

  // R11: an abort event yields an error pulse and a closed window
  p_abort_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (hdr_err && !cip));

  // R6: address bytes arrive back to back after the first one
  p_addr_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && addr_idx != '0) |-> $past(addr_strobe));

  // R3: the first destination byte directly follows an accepted frame control
  p_fc_before_da_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && !addr_sa && addr_idx == '0) |-> $past(fc_strobe && fc_filter));

  // R7: end and error never coincide
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_done && hdr_err));
endmodule

bind rxhdr_parser rxhdr_parser_chk #(
  .CIP_RISE (CIP_RISE),
  .CIP_FALL (CIP_FALL),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fc_strobe   (fc_strobe),
  .fc_filter   (fc_filter),
  .addr_strobe (addr_strobe),
  .addr_sa     (addr_sa),
  .addr_idx    (addr_idx),
  .hdr_done    (hdr_done),
  .hdr_err     (hdr_err),
  .cip         (cip),
  .ev_abort    (ev_abort)
);

// File: tb/test_rxhdr_parser.sv
module test_rxhdr_parser;
  localparam logic [7:0] SD = 8'hC5;
  localparam int K_FC = 0, K_ADDR = 1, K_HDR = 2, K_ERR = 3, K_UP = 4, K_DN = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_tag = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tag_a = 1'b0, tag_b = 1'b0, rx_parity = 1'b0;
  logic       fc_strobe, fc_filter, addr_strobe, addr_sa;
  logic [2:0] fc_class, addr_idx;
  logic [7:0] addr_byte;
  logic       rif_present, hdr_done, hdr_err, cip;
  logic [4:0] rif_len;

  int  cyc = 0;
  int  checks = 0, errors = 0;
  bit  mon_on = 0, done = 0;
  logic cip_q = 1'b0;

  typedef struct {
    int    kind;
    int    at;
    int    data;
    string req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxhdr_parser i_rxhdr_parser (
    .clk(clk), .rst_n(rst_n), .two_tag_mode(two_tag), .rx_byte(rx_byte),
    .tag_a(tag_a), .tag_b(tag_b), .rx_parity(rx_parity),
    .fc_strobe(fc_strobe), .fc_class(fc_class), .fc_filter(fc_filter),
    .addr_strobe(addr_strobe), .addr_sa(addr_sa), .addr_idx(addr_idx),
    .addr_byte(addr_byte), .rif_present(rif_present), .rif_len(rif_len),
    .hdr_done(hdr_done), .hdr_err(hdr_err), .cip(cip)
  );

  function automatic string kind_req(input int k);
    case (k)
      K_FC: return "R3"; K_ADDR: return "R6"; K_HDR: return "R7";
      K_ERR: return "R11"; K_UP: return "R8"; default: return "R9";
    endcase
  endfunction

  // class codes restated from the requirement text
  function automatic int exp_class(input logic [7:0] fc);
    if (fc == 8'h80 || fc == 8'hC0) return 0;
    if ((fc & 8'hB0) == 8'h00) return (fc[3:0] == 0) ? 1 : 2;
    if ((fc & 8'hB0) == 8'h80) return 3;
    if (fc[5:4] == 2'b01) return 4;
    return 5;
  endfunction

  task automatic expect_ev(input int k, input int at, input int data, input string req);
    exp_t e;
    e.kind = k; e.at = at; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(input int k, input int data);
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].kind == k && q[i].at == cyc) begin
        checks++;
        if (q[i].data != data) begin
          errors++;
          $display("FAIL %s kind %0d cycle %0d: actual=%h expected=%h",
                   q[i].req, k, cyc, data, q[i].data);
        end
        q.delete(i);
        return;
      end
    end
    checks++;
    errors++;
    $display("FAIL %s unexpected kind %0d cycle %0d: actual=%h expected=none",
             kind_req(k), k, cyc, data);
  endtask

  // scoreboard monitor: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (fc_strobe)   observe(K_FC, int'({fc_filter, fc_class}));
      if (addr_strobe) observe(K_ADDR, int'({addr_sa, addr_idx, addr_byte}));
      if (hdr_done)    observe(K_HDR, int'({rif_present, rif_len}));
      if (hdr_err)     observe(K_ERR, 0);
      if (cip && !cip_q) observe(K_UP, 0);
      if (!cip && cip_q) observe(K_DN, 0);
    end
    cip_q = cip;
  end

  task automatic put(input logic [7:0] b, input logic ta, input logic tb,
                     input logic badp, output int l);
    @(negedge clk);
    rx_byte   = b;
    tag_a     = ta;
    tag_b     = tb;
    rx_parity = ~(^{b, ta, two_tag & tb}) ^ badp;   // R1 odd parity
    l = cyc + 1;
  endtask

  task automatic idle(input int n);
    int l;
    for (int i = 0; i < n; i++) put(8'h00, 1'b0, 1'b0, 1'b0, l);
  endtask

  // err_kind: 0 bad parity, 1 control tag, 2 no corruption but error expected
  task automatic send_hdr(input logic [7:0] fc, input logic [47:0] da,
                          input logic [47:0] sa, input int rlen, input int err_at,
                          input int err_kind, input logic stray_tb, input string ereq);
    int l, cls, n_hdr;
    logic flt, rif, corrupt, ta, tb;
    logic [7:0] b;
    rif = sa[47];
    cls = exp_class(fc);
    flt = fc[6] && cls >= 3;
    put(SD, 1'b1, two_tag, 1'b0, l);
    n_hdr = !flt ? 1 : (rif ? ((rlen < 2) ? 14 : 13 + rlen) : 13);
    for (int i = 0; i < n_hdr; i++) begin
      if (i == 0)       b = fc;
      else if (i <= 6)  b = da[47 - 8*(i-1) -: 8];
      else if (i <= 12) b = sa[47 - 8*(i-7) -: 8];
      else if (i == 13) b = {3'b000, 5'(rlen)};
      else              b = 8'h30 + 8'(i);
      corrupt = (i == err_at) && err_kind < 2;
      ta = corrupt && err_kind == 1;
      tb = stray_tb && i > 0;
      put(b, ta, tb, corrupt && err_kind == 0, l);
      if (i == err_at) begin
        expect_ev(K_ERR, l, 0, ereq);
        if (i > 3) expect_ev(K_DN, l, 0, "R11");
        break;
      end
      if (i == 0)
        expect_ev(K_FC, l, int'({flt, 3'(cls)}), cls == 0 ? "R4" : (!flt ? "R5" : "R3"));
      else if (i <= 12)
        expect_ev(K_ADDR, l, int'({i > 6, 3'((i - 1) % 6), b}), "R6");
      if (i == 3) expect_ev(K_UP, l, 0, "R8");
      if (flt && i == n_hdr - 1) begin
        expect_ev(K_HDR, l, int'({rif, rif ? 5'(rlen) : 5'd0}), "R7");
        expect_ev(K_DN, l + 7, 0, rif ? "R10" : "R9");
      end
    end
    idle(14);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state (R8)
    checks++;
    if (cip || fc_strobe || addr_strobe || hdr_done || hdr_err || rif_present) begin
      errors++;
      $display("FAIL R8 reset: actual=%b%b%b%b%b%b expected=000000",
               cip, fc_strobe, addr_strobe, hdr_done, hdr_err, rif_present);
    end
    mon_on = 1;
    idle(4);
    // one-tag mode: plain LLC frame (R3 R6 R8 R9)
    send_hdr(8'h50, 48'h0102_0304_0506, 48'h1112_1314_1516, 0, -1, 0, 1'b0, "");
    // MAC frame with stray tag_b that one-tag mode must ignore (R2)
    send_hdr(8'hC1, 48'hA1A2_A3A4_A5A6, 48'h7172_7374_7576, 0, -1, 0, 1'b1, "");
    // tokens (R4)
    send_hdr(8'h80, 48'h0, 48'h0, 0, -1, 0, 1'b0, "");
    send_hdr(8'hC0, 48'h0, 48'h0, 0, -1, 0, 1'b0, "");
    // void, management, short-address LLC (R5)
    send_hdr(8'h40, 48'h0, 48'h0, 0, -1, 0, 1'b0, "");
    send_hdr(8'h41, 48'h0, 48'h0, 0, -1, 0, 1'b0, "");
    send_hdr(8'h10, 48'h0, 48'h0, 0, -1, 0, 1'b0, "");
    // bad parity on frame control: error only (R1)
    send_hdr(8'h50, 48'h0, 48'h0, 0, 0, 0, 1'b0, "R1");
    // two-tag mode
    two_tag = 1'b1;
    idle(2);
    // routing field of 6 bytes (R7 R10)
    send_hdr(8'h51, 48'hCAFE_0000_BEEF, 48'h8899_AABB_CCDD, 6, -1, 0, 1'b0, "");
    // reserved class, no routing field
    send_hdr(8'h60, 48'h2233_4455_6677, 48'h0123_4567_89AB, 0, -1, 0, 1'b0, "");
    // half-tagged start byte must not open a frame (R2): no event may follow
    begin
      int l;
      put(SD, 1'b1, 1'b0, 1'b0, l);
      put(8'h50, 1'b0, 1'b0, 1'b0, l);
      for (int i = 0; i < 12; i++) put(8'h11 * 8'(i), 1'b0, 1'b0, 1'b0, l);
      idle(10);
    end
    // parity error in third source byte (R1)
    send_hdr(8'h50, 48'h0A0B_0C0D_0E0F, 48'h1020_3040_5060, 0, 9, 0, 1'b0, "R1");
    // control symbol in second destination byte, before the window opens (R11)
    send_hdr(8'h50, 48'h0A0B_0C0D_0E0F, 48'h1020_3040_5060, 0, 2, 1, 1'b0, "R11");
    // illegal routing length 1 (R12)
    send_hdr(8'h54, 48'h0A0B_0C0D_0E0F, 48'h9020_3040_5060, 1, 13, 2, 1'b0, "R12");
    idle(10);
    mon_on = 0;
    foreach (q[i]) begin
      checks++;
      errors++;
      $display("FAIL %s kind %0d cycle %0d: actual=missing expected=%h",
               q[i].req, q[i].kind, q[i].at, q[i].data);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule